// File: doc/BRIEF.md
# Supply-Qualified Reset Generator

This block turns two digital supply flags into one active-low system reset. One flag says whether the logic-rail feedback is good; the other says whether the high-voltage bulk supply is good. Both come from analog comparators that run off their own timing, so the block passes them through two flip-flops before using them. A short drop of the logic-rail flag is filtered out. A drop that lasts for the persistence time is treated as a real brown-out. Once the logic rail is good again, the reset stays held for a fixed number of cycles counted from that moment. The bulk flag can hold reset on its own, and when it recovers after the delay has already run out, reset lets go at once.

The block drives an open-drain request, `rst_drive_n`, where 0 means pull the pad low. The pad itself may also be pulled low by another source. The level seen on the pad comes back on `rst_pin_in`, is synchronised, and is handed to the rest of the chip as `sys_rst_n`. The rest of the chip therefore sees every reset on the pad, whether this block caused it or not.

The control is a four-state machine:
- **HOLD**: the filtered rail is bad.
- **DELAY**: the rail is good and the release timer is running.
- **WAIT_BULK**: the timer has run out but the bulk supply is bad.
- **RUN**: reset is released.

The transitions are:
- **HOLD→DELAY**: the rail becomes good.
- **DELAY→RUN**: the timer has run out and bulk is good.
- **DELAY→WAIT_BULK**: the timer has run out and bulk is bad.
- **WAIT_BULK→RUN**: bulk becomes good.
- **RUN→WAIT_BULK**: bulk falls.
- **any state→HOLD**: the filtered rail is lost.

`rst_drive_n` is 1 only in RUN.

Top module: `rstgen_supervisor`

## Requirements
- R1: `rst_drive_n` is 0 whenever the filtered rail status or the synchronised bulk flag was low at the previous clock edge.
- R2: A raw input (`logic_ok_raw`, `bulk_ok_raw`, `rst_pin_in`) reaches the internal logic only after two register stages. The first rising edge that samples a new value counts as edge 1.
- R3: With bulk good, a rise of `logic_ok_raw` from a bad-rail state drives `rst_drive_n` to 1 at edge DELAY_CYC+4, counting the first edge that samples the raw flag high.
- R4: If bulk becomes good partway through the delay, release still happens at edge DELAY_CYC+4 counted from the rail rise. It does not happen earlier.
- R5: If the rail has been good longer than the delay and bulk is bad, a rise of `bulk_ok_raw` drives `rst_drive_n` to 1 at edge 3.
- R6: A run of fewer than PERSIST_CYC consecutive low synchronised samples of the rail flag leaves `rst_drive_n` at 1.
- R7: A raw rail drop of at least PERSIST_CYC cycles drives `rst_drive_n` to 0 at edge PERSIST_CYC+3. When the rail returns, the full delay of R3 is measured again from the return.
- R8: A fall of `bulk_ok_raw` drives `rst_drive_n` to 0 at edge 3, even though the rail stays good.
- R9: `sys_rst_n` follows the pad level `rst_pin_in` two edges later. A low driven onto the pad from outside reaches `sys_rst_n` without changing `rst_drive_n`.
- R10: While `rst_n` is low, `rst_drive_n` and `sys_rst_n` are 0 and all timing state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous power-on clear, active low |
| logic_ok_raw | input | 1 | Logic-rail comparator flag, 1 = good, asynchronous |
| bulk_ok_raw | input | 1 | Bulk-supply comparator flag, 1 = good, asynchronous |
| rst_pin_in | input | 1 | Level sensed on the shared reset pad |
| rst_drive_n | output | 1 | Open-drain request, 0 = pull pad low |
| sys_rst_n | output | 1 | Synchronised pad level for on-chip use |

## Verification
The bench builds the block with DELAY_CYC = 40 and PERSIST_CYC = 6. These short windows keep the run fast, but they still let the bench produce a dip one sample shorter than the persistence threshold, a dip that just crosses it, and a bulk recovery on either side of the delay boundary. With these values, the release edge can be counted exactly against DELAY_CYC+4 within a few hundred cycles. The bench also reaches the state where bulk falls back while the rail stays good.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
    typedef enum logic [1:0] {
        ST_HOLD      = 2'd0,
        ST_DELAY     = 2'd1,
        ST_WAIT_BULK = 2'd2,
        ST_RUN       = 2'd3
    } sup_state_t;

    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    import rstgen_pkg::*;

    logic [WIDTH-1:0] stage_q [SYNC_STAGES];

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else begin
                    stage_q[g] <= (g == 0) ? d : stage_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign q = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/rstgen_dip_filter.sv
module rstgen_dip_filter #(
    parameter int PERSIST_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_in,
    output logic rail_ok
);
    localparam int CW = $clog2(PERSIST_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(PERSIST_CYC - 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rail_ok <= 1'b0;
            low_cnt <= '0;
        end else if (rail_ok) begin
            if (rail_in) begin
                low_cnt <= '0;
            end else if (low_cnt == LAST) begin
                low_cnt <= '0;
                rail_ok <= 1'b0;
            end else begin
                low_cnt <= low_cnt + CW'(1);
            end
        end else begin
            low_cnt <= '0;
            if (rail_in) rail_ok <= 1'b1;
        end
    end

    // R6: a good sample never lets the filtered status drop
    a_r6_good_sample_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_ok && rail_in) |=> rail_ok);

    // R7: filtered status falls only after a low sample
    a_r7_drop_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rail_ok) |-> !$past(rail_in));
endmodule

// File: rtl/rstgen_delay_timer.sv
module rstgen_delay_timer #(
    parameter int DELAY_CYC = 33000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic elapsed
);
    localparam int CW = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            elapsed <= 1'b0;
        end else if (!run) begin
            cnt     <= '0;
            elapsed <= 1'b0;
        end else if (!elapsed) begin
            if (cnt == LAST) elapsed <= 1'b1;
            else             cnt <= cnt + CW'(1);
        end
    end

    // R7: losing the rail restarts the full delay
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !elapsed);

    // R3: elapsed can only appear while the rail has been good
    a_r3_elapsed_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(elapsed) |-> $past(run));
endmodule

// File: rtl/rstgen_supervisor.sv
module rstgen_supervisor #(
    parameter int DELAY_CYC   = 33000,
    parameter int PERSIST_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic logic_ok_raw,
    input  logic bulk_ok_raw,
    input  logic rst_pin_in,
    output logic rst_drive_n,
    output logic sys_rst_n
);
    import rstgen_pkg::*;

    logic [2:0] raw_vec;
    logic [2:0] syn_vec;
    logic       rail_s;
    logic       bulk_s;
    logic       rail_ok;
    logic       elapsed;
    sup_state_t state_q;
    sup_state_t state_d;

    assign raw_vec = {rst_pin_in, bulk_ok_raw, logic_ok_raw};

    rstgen_sync #(.WIDTH(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_vec),
        .q    (syn_vec)
    );

    assign rail_s    = syn_vec[0];
    assign bulk_s    = syn_vec[1];
    assign sys_rst_n = syn_vec[2];

    rstgen_dip_filter #(.PERSIST_CYC(PERSIST_CYC)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .rail_in(rail_s),
        .rail_ok(rail_ok)
    );

    rstgen_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (rail_ok),
        .elapsed(elapsed)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (rail_ok) state_d = ST_DELAY;
            end
            ST_DELAY: begin
                if (!rail_ok)             state_d = ST_HOLD;
                else if (elapsed && bulk_s)  state_d = ST_RUN;
                else if (elapsed)            state_d = ST_WAIT_BULK;
            end
            ST_WAIT_BULK: begin
                if (!rail_ok)    state_d = ST_HOLD;
                else if (bulk_s) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!rail_ok)     state_d = ST_HOLD;
                else if (!bulk_s) state_d = ST_WAIT_BULK;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        rst_drive_n = (state_q == ST_RUN);
    end

    // R1: a bad rail forces reset on the next cycle
    a_r1_rail_bad_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rail_ok |=> !rst_drive_n);

    // R8: a bad bulk flag forces reset on the next cycle
    a_r8_bulk_bad_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bulk_s |=> !rst_drive_n);

    // R4: release only after the delay has run out
    a_r4_release_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_drive_n) |-> $past(elapsed));

    // R10: under clear the request is low
    a_r10_clear_low: assert property (@(posedge clk) !rst_n |-> !rst_drive_n);
endmodule

// File: tb/sim_rstgen_supervisor.sv
module sim_rstgen_supervisor;
    localparam int D = 40;
    localparam int P = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic logic_ok_raw = 1'b0;
    logic bulk_ok_raw = 1'b0;
    logic ext_n = 1'b1;
    logic rst_pin_in;
    logic rst_drive_n;
    logic sys_rst_n;

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;

    always #4 clk = ~clk;

    assign rst_pin_in = rst_drive_n & ext_n;

    rstgen_supervisor #(.DELAY_CYC(D), .PERSIST_CYC(P)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .logic_ok_raw(logic_ok_raw),
        .bulk_ok_raw (bulk_ok_raw),
        .rst_pin_in  (rst_pin_in),
        .rst_drive_n (rst_drive_n),
        .sys_rst_n   (sys_rst_n)
    );

    // Behavioural reference: flag histories plus good-time counters
    int  m_good_run, m_low_run;
    bit  m_l1, m_l2, m_b1, m_b2, m_p1, m_p2;
    bit  m_ok, m_drv;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_l1 = 0; m_l2 = 0; m_b1 = 0; m_b2 = 0; m_p1 = 0; m_p2 = 0;
            m_ok = 0; m_drv = 0; m_good_run = 0; m_low_run = 0;
        end else begin
            bit pin_now, nxt_ok, nxt_drv;
            int nxt_good;
            pin_now = m_drv & ext_n;
            nxt_drv = m_ok && (m_good_run >= D) && m_b2;
            nxt_good = m_ok ? m_good_run + 1 : 0;
            nxt_ok = m_ok;
            if (m_ok) begin
                if (m_l2) m_low_run = 0;
                else begin
                    m_low_run++;
                    if (m_low_run >= P) begin
                        nxt_ok = 0;
                        m_low_run = 0;
                    end
                end
            end else begin
                m_low_run = 0;
                if (m_l2) nxt_ok = 1;
            end
            m_good_run = nxt_good;
            m_ok = nxt_ok;
            m_drv = nxt_drv;
            m_p2 = m_p1; m_p1 = pin_now;
            m_l2 = m_l1; m_l1 = logic_ok_raw;
            m_b2 = m_b1; m_b1 = bulk_ok_raw;
        end
    end

    task automatic chk(input int act, input int exp, input string tag, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk(int'(rst_drive_n), int'(m_drv), "R1", "per-cycle drive vs model");
            chk(int'(sys_rst_n), int'(m_p2), "R9", "per-cycle sensed pin vs model");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wait_drive(input bit lvl, output int n);
        n = 0;
        while (n < 1000) begin
            @(negedge clk);
            n++;
            if (rst_drive_n == lvl) break;
        end
    endtask

    task automatic wait_sys(input bit lvl, output int n);
        n = 0;
        while (n < 1000) begin
            @(negedge clk);
            n++;
            if (sys_rst_n == lvl) break;
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    initial begin
        int n;
        bit stayed;
        idle(3);
        // R10: clear state
        chk(int'(rst_drive_n), 0, "R10", "drive under clear");
        chk(int'(sys_rst_n), 0, "R10", "sensed pin under clear");
        rst_n = 1'b1;
        cmp_en = 1'b1;
        idle(4);
        chk(int'(rst_drive_n), 0, "R1", "drive with both flags bad");

        // R3 / R2: both good together
        bulk_ok_raw = 1'b1;
        logic_ok_raw = 1'b1;
        wait_drive(1'b1, n);
        chk(n, D + 4, "R3", "release edge after rail rise");
        idle(5);
        chk(int'(sys_rst_n), 1, "R9", "sensed pin follows release");

        // R6: short dip ignored
        logic_ok_raw = 1'b0;
        idle(P - 1);
        logic_ok_raw = 1'b1;
        stayed = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!rst_drive_n) stayed = 1'b0;
        end
        chk(int'(stayed), 1, "R6", "short rail dip leaves reset released");

        // R8 / R2: bulk fall while rail good
        bulk_ok_raw = 1'b0;
        wait_drive(1'b0, n);
        chk(n, 3, "R8", "assert edge after bulk fall");
        idle(D + 5);
        // R5: bulk returns after delay is long past
        bulk_ok_raw = 1'b1;
        wait_drive(1'b1, n);
        chk(n, 3, "R5", "release edge after late bulk rise");
        chk(n, 3, "R2", "two-stage sync latency on bulk flag");

        // R7: persistent dip
        idle(3);
        logic_ok_raw = 1'b0;
        wait_drive(1'b0, n);
        chk(n, P + 3, "R7", "assert edge after persistent dip");
        idle(P + 4);
        logic_ok_raw = 1'b1;
        wait_drive(1'b1, n);
        chk(n, D + 4, "R7", "full delay restarts after dip");

        // R4: bulk recovers mid-delay
        bulk_ok_raw = 1'b0;
        logic_ok_raw = 1'b0;
        idle(P + 8);
        logic_ok_raw = 1'b1;
        idle(D / 2);
        bulk_ok_raw = 1'b1;
        wait_drive(1'b1, n);
        chk(n + D / 2, D + 4, "R4", "release edge with mid-delay bulk rise");

        // R9: outside source pulls pad low
        idle(4);
        ext_n = 1'b0;
        wait_sys(1'b0, n);
        chk(n, 2, "R9", "sensed pin falls after external pull");
        chk(int'(rst_drive_n), 1, "R9", "drive unaffected by external pull");
        ext_n = 1'b1;
        wait_sys(1'b1, n);
        chk(n, 2, "R9", "sensed pin recovers");

        // R10: clear in the middle of operation
        rst_n = 1'b0;
        #1;
        chk(int'(rst_drive_n), 0, "R10", "drive cleared asynchronously");
        chk(int'(sys_rst_n), 0, "R10", "sensed pin cleared asynchronously");
        idle(2);
        rst_n = 1'b1;
        wait_drive(1'b1, n);
        chk(n, D + 4, "R10", "timing state restarts after clear");

        idle(3);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule